// File: doc/BRIEF.md
# Crosspoint switch control memory

This block stores the on/off state of a crosspoint array of 4 rows by 8 columns, one control bit per crossing. A bit is picked by a 2-bit row address and a 3-bit column address. It is written from a single data line while both the select and strobe pins are high. During that window the addressed bit tracks the data line continuously. When strobe drops, the bit keeps the last value it took.

A master clear forces every bit to off at once, whatever select and strobe are doing. The control pins are sampled on the system clock, so the block sits in one clock domain. The 32 enables drive the analog switch drivers directly.

The control path has no payload stream, so there is no valid/ready handshake. Every pin is a plain level. The caller holds the address steady for as long as strobe is high and sets the data line to its final value before dropping strobe.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While `clr_all` is high, `sw_on` is all zeros, including in the same cycle that `clr_all` rises with no clock edge between, regardless of `sel` and `stb`.
- R2: A write attempted while `clr_all` is high (sel=1, stb=1, wr_data=1) leaves `sw_on` all zeros, both during the clear and after it is released with the pins idle.
- R3: The addressed bit is `sw_on[row_sel*8 + col_sel]`, with `row_sel[0]` the row LSB and `col_sel[0]` the column LSB. For example, row 1 column 0 is bit 8 and row 2 column 7 is bit 23.
- R4: Writing 1 turns the addressed bit on and writing 0 turns it off. No other bit of `sw_on` changes.
- R5: With `sel` low, strobe pulses with any data and address leave `sw_on` unchanged.
- R6: While `sel` and `stb` are both high, the addressed bit follows `wr_data`. A change on the pins shows on `sw_on` after the second rising clock edge.
- R7: After `stb` falls, the bit keeps the `wr_data` value last sampled with strobe high. Later changes on `wr_data` with strobe low have no effect.
- R8: If the address moves while strobe is high, the newly addressed bit is written. The earlier bit keeps the last value it followed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the control pins |
| clr_all | input | 1 | Master clear, active high, asynchronous |
| sel | input | 1 | Chip select, active high |
| stb | input | 1 | Write strobe, active high, level-sensitive |
| wr_data | input | 1 | Value for the addressed bit (1 = on) |
| row_sel | input | 2 | Row address |
| col_sel | input | 3 | Column address |
| sw_on | output | 32 | Switch enables, bit index row*8+col |

## Verification
The hardest case to reach from the ports is the instant strobe falls. The value that sticks is the one sampled with strobe still high, not whatever is on the data line as strobe goes low. The stimulus drops strobe and flips the data line in the same cycle, then toggles data repeatedly with strobe low and checks that the bit stays put. A second hard case is an address that moves in the middle of a strobe. It is reached by holding strobe high across two addresses and changing data after the move, so the two bits must end with different values.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int XPT_ROWS_DEF = 4;
  localparam int XPT_COLS_DEF = 8;

  function automatic int flat_index(input int row, input int col, input int cols);
    return row * cols + col;
  endfunction
endpackage

// File: rtl/xpt_pin_sampler.sv
module xpt_pin_sampler #(
  parameter int RW = 2,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          clr_all,
  input  logic          sel,
  input  logic          stb,
  input  logic          wr_data,
  input  logic [RW-1:0] row_sel,
  input  logic [CW-1:0] col_sel,
  output logic          sel_q,
  output logic          stb_q,
  output logic          data_q,
  output logic [RW-1:0] row_q,
  output logic [CW-1:0] col_q
);
  always_ff @(posedge clk or posedge clr_all) begin
    if (clr_all) begin
      sel_q  <= 1'b0;
      stb_q  <= 1'b0;
      data_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      sel_q  <= sel;
      stb_q  <= stb;
      data_q <= wr_data;
      row_q  <= row_sel;
      col_q  <= col_sel;
    end
  end
endmodule

// File: rtl/xpt_addr_decode.sv
module xpt_addr_decode #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int N  = ROWS * COLS
) (
  input  logic          sel_q,
  input  logic          stb_q,
  input  logic [RW-1:0] row_q,
  input  logic [CW-1:0] col_q,
  output logic [N-1:0]  cell_en
);
  logic open_win;
  assign open_win = sel_q & stb_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_hit;
    assign row_hit = (row_q == RW'(r));
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign cell_en[r*COLS + c] = open_win & row_hit & (col_q == CW'(c));
    end
  end
endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         clr_all,
  input  logic [N-1:0] cell_en,
  input  logic         data_q,
  output logic [N-1:0] cells
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk or posedge clr_all) begin
      if (clr_all)
        cells[i] <= 1'b0;
      else if (cell_en[i])
        cells[i] <= data_q;
    end
  end
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem #(
  parameter int ROWS = xpt_pkg::XPT_ROWS_DEF,
  parameter int COLS = xpt_pkg::XPT_COLS_DEF,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int N  = ROWS * COLS
) (
  input  logic          clk,
  input  logic          clr_all,
  input  logic          sel,
  input  logic          stb,
  input  logic          wr_data,
  input  logic [RW-1:0] row_sel,
  input  logic [CW-1:0] col_sel,
  output logic [N-1:0]  sw_on
);
  logic          sel_q, stb_q, data_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [N-1:0]  cell_en;

  xpt_pin_sampler #(.RW(RW), .CW(CW)) u_sampler (
    .clk(clk), .clr_all(clr_all),
    .sel(sel), .stb(stb), .wr_data(wr_data),
    .row_sel(row_sel), .col_sel(col_sel),
    .sel_q(sel_q), .stb_q(stb_q), .data_q(data_q),
    .row_q(row_q), .col_q(col_q)
  );

  xpt_addr_decode #(.ROWS(ROWS), .COLS(COLS)) u_decode (
    .sel_q(sel_q), .stb_q(stb_q), .row_q(row_q), .col_q(col_q),
    .cell_en(cell_en)
  );

  xpt_cell_array #(.N(N)) u_cells (
    .clk(clk), .clr_all(clr_all), .cell_en(cell_en),
    .data_q(data_q), .cells(sw_on)
  );
endmodule

// File: rtl/xpt_ctrl_mem_chk.sv
module xpt_ctrl_mem_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int N  = ROWS * COLS
) (
  input logic          clk,
  input logic          clr_all,
  input logic          sel,
  input logic          stb,
  input logic          wr_data,
  input logic [RW-1:0] row_sel,
  input logic [CW-1:0] col_sel,
  input logic [N-1:0]  sw_on
);
  logic [2:0] warm;
  logic       settled;

  always_ff @(posedge clk or posedge clr_all) begin
    if (clr_all)
      warm <= '0;
    else if (warm != 3'd4)
      warm <= warm + 3'd1;
  end
  assign settled = (warm == 3'd4);

  // R1
  always @(negedge clk) begin
    if (clr_all)
      a_clear_zero_r1: assert (sw_on == '0);
  end

  p_desel_hold_r5: assert property (@(posedge clk) disable iff (clr_all)
    (settled && !($past(sel, 2) && $past(stb, 2))) |-> $stable(sw_on));

  p_write_lands_r6: assert property (@(posedge clk) disable iff (clr_all)
    (settled && $past(sel, 2) && $past(stb, 2)) |->
      (sw_on[{$past(row_sel, 2), $past(col_sel, 2)}] == $past(wr_data, 2)));

  p_single_bit_r4: assert property (@(posedge clk) disable iff (clr_all)
    settled |-> ($countones(sw_on ^ $past(sw_on)) <= 1));

  p_hold_after_fall_r7: assert property (@(posedge clk) disable iff (clr_all)
    (settled && $past(stb, 3) && !$past(stb, 2)) |-> $stable(sw_on));
endmodule

bind xpt_ctrl_mem xpt_ctrl_mem_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .clr_all(clr_all), .sel(sel), .stb(stb), .wr_data(wr_data),
  .row_sel(row_sel), .col_sel(col_sel), .sw_on(sw_on)
);

// File: tb/test_xpt_ctrl_mem.sv
module test_xpt_ctrl_mem;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int N = ROWS * COLS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         clr_all, sel, stb, wr_data;
  logic [1:0]   row_sel;
  logic [2:0]   col_sel;
  logic [N-1:0] sw_on;
  logic [N-1:0] model;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  xpt_ctrl_mem #(.ROWS(ROWS), .COLS(COLS)) i_xpt_ctrl_mem (
    .clk(clk), .clr_all(clr_all), .sel(sel), .stb(stb), .wr_data(wr_data),
    .row_sel(row_sel), .col_sel(col_sel), .sw_on(sw_on)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: cycles=%0d expected below 50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [N-1:0] exp);
    n_chk++;
    if (sw_on !== exp) begin
      n_fail++;
      $display("FAIL %s: sw_on=%h expected %h", tag, sw_on, exp);
    end
  endtask

  task automatic idle();
    sel = 1'b0; stb = 1'b0; wr_data = 1'b0;
  endtask

  task automatic put_addr(int r, int c);
    row_sel = r[1:0];
    col_sel = c[2:0];
  endtask

  task automatic write_bit(int r, int c, logic d);
    sel = 1'b1; stb = 1'b1; wr_data = d; put_addr(r, c);
    tick(1);
    idle();
    tick(2);
    model[5'(r*COLS + c)] = d;
  endtask

  task automatic t_reset_state();
    clr_all = 1'b1; idle(); put_addr(0, 0);
    model = '0;
    tick(3);
    chk("R1 reset state", '0);
    sel = 1'b1; stb = 1'b1; wr_data = 1'b1; put_addr(2, 5);
    tick(3);
    chk("R2 write during clear", '0);
    idle();
    tick(1);
    clr_all = 1'b0;
    tick(3);
    chk("R2 after clear release", '0);
  endtask

  task automatic t_decode();
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        write_bit(r, c, 1'b1);
        chk($sformatf("R3 row %0d col %0d", r, c), model);
        write_bit(r, c, 1'b0);
      end
    end
    chk("R3 walk back to zero", '0);
  endtask

  task automatic t_pattern();
    for (int i = 0; i < N; i += 3) begin
      write_bit(i / COLS, i % COLS, 1'b1);
      chk($sformatf("R4 set bit %0d", i), model);
    end
    for (int i = 0; i < N; i += 6) begin
      write_bit(i / COLS, i % COLS, 1'b0);
      chk($sformatf("R4 clear bit %0d", i), model);
    end
    write_bit(1, 1, 1'b1);
    write_bit(1, 1, 1'b1);
    chk("R4 rewrite same value", model);
  endtask

  task automatic t_deselected();
    for (int i = 1; i < N; i += 5) begin
      sel = 1'b0; stb = 1'b1; put_addr(i / COLS, i % COLS);
      wr_data = ~model[5'(i)];
      tick(2);
      wr_data = ~wr_data;
      tick(1);
      idle();
      tick(2);
      chk($sformatf("R5 deselected strobe bit %0d", i), model);
    end
  endtask

  task automatic t_follow();
    sel = 1'b1; stb = 1'b1; put_addr(2, 5);
    for (int k = 0; k < 6; k++) begin
      wr_data = k[0] ? 1'b0 : 1'b1;
      model[21] = wr_data;
      tick(2);
      chk($sformatf("R6 follow step %0d", k), model);
    end
  endtask

  task automatic t_fall();
    wr_data = 1'b1;
    model[21] = 1'b1;
    tick(1);
    stb = 1'b0; wr_data = 1'b0;
    tick(2);
    chk("R7 value at strobe fall", model);
    for (int k = 0; k < 4; k++) begin
      wr_data = ~wr_data;
      tick(1);
    end
    tick(2);
    chk("R7 data moves after fall", model);
    idle();
    tick(2);
  endtask

  task automatic t_move();
    sel = 1'b1; stb = 1'b1; wr_data = 1'b1; put_addr(1, 3);
    tick(1);
    put_addr(3, 6);
    tick(1);
    wr_data = 1'b0;
    tick(1);
    idle();
    tick(2);
    model[11] = 1'b1;
    model[30] = 1'b0;
    chk("R8 address moves mid strobe", model);
  endtask

  task automatic t_async_clear();
    write_bit(0, 7, 1'b1);
    write_bit(3, 0, 1'b1);
    chk("R4 bits set before clear", model);
    #5 clr_all = 1'b1;
    #2 chk("R1 clear without clock edge", '0);
    model = '0;
    tick(2);
    clr_all = 1'b0;
    tick(2);
    chk("R1 zero after release", '0);
  endtask

  initial begin
    clr_all = 1'b1;
    idle();
    put_addr(0, 0);
    model = '0;
    tick(1);
    t_reset_state();
    t_decode();
    t_pattern();
    t_deselected();
    t_follow();
    t_fall();
    t_move();
    t_async_clear();
    summary();
    $finish;
  end
endmodule